// File: doc/BRIEF.md
# Rate-1/5 Parallel Turbo Encoder

This block turns a framed stream of message bits into a stream of five-bit code groups. It contains two identical recursive systematic convolutional encoders of constraint length 4. The first encoder sees each message bit in natural order. The second encoder sees the same message, already permuted by an external interleaver, one bit per beat on a separate input pin. For every accepted message bit the block emits the systematic bit and the two parity bits of the first encoder, followed by the two parity bits of the second encoder. The systematic bit of the second encoder is never emitted.

A frame opens with a start marker and closes with an end marker on the input handshake. After the closing bit, both encoders terminate their trellises for three cycles. In each of those cycles, the encoder's own feedback value replaces the message bit, which drives the delay line to the all-zero state. During those cycles the input is not ready, and the three resulting groups carry a tail flag. The output is a plain valid-qualified group with no backpressure. Address generation for the interleaver, puncturing and frame storage belong to neighbouring blocks.

Top module: `turbo_encoder`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat is taken when `in_valid` and `in_ready` are both high and either `in_sof` is high or a frame is open. Each taken beat yields exactly one group, with `out_valid` high and `out_tail` low, in the cycle after the taking edge.
- R3: Group bit 4 is the systematic bit X. For a taken beat, X equals `in_bit`. Bits 3 and 2 are the first encoder's parities Y0 and Y1. Bits 1 and 0 are the second encoder's parities Y0' and Y1'.
- R4: Each encoder holds delay bits d1 (newest), d2 and d3. The feedback is f = d2 xor d3. The applied input is u, and the node value is a = u xor f. The parities are Y0 = a xor d1 xor d3 and Y1 = a xor d1 xor d2 xor d3. After the step, the delay line becomes (a, d1, d2).
- R5: The second encoder follows the R4 rule with `in_ibit` as its message input, and it fills bits 1 and 0 of the group.
- R6: A taken beat with `in_sof` high encodes from the all-zero state in both encoders, even when it arrives inside an open frame.
- R7: A taken beat with `in_eof` high closes the frame. Its data group is followed, on the next three consecutive cycles, by three groups with `out_valid` and `out_tail` both high.
- R8: In each tail step, each encoder applies u = f. X in a tail group is the first encoder's applied u. After the third tail step, both encoders hold the all-zero state.
- R9: `in_ready` is low for exactly the three tail cycles, and no beat is taken in them. It is high in every other cycle.
- R10: A beat offered while no frame is open and without `in_sof` is consumed and dropped. It produces no group.
- R11: A single beat with both `in_sof` and `in_eof` high forms a one-bit frame: one data group followed by three tail groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat (low during tail) |
| in_sof | input | 1 | Beat is the first bit of a frame |
| in_eof | input | 1 | Beat is the last bit of a frame |
| in_bit | input | 1 | Message bit in natural order |
| in_ibit | input | 1 | Message bit in interleaved order |
| out_valid | output | 1 | Output group present |
| out_sym | output | 5 | Code group {X, Y0, Y1, Y0', Y1'}, X in bit 4 |
| out_tail | output | 1 | Group comes from trellis termination |

## Verification
The group for a taken beat is due one clock after the taking edge. The three tail groups are due on the three clocks after that. `in_ready` changes at the edge that takes the closing beat and again at the edge after the third tail step. The bench drives inputs on the falling edge. At that same falling edge it first compares the outputs against a behavioural model, whose prediction was formed at the previous falling edge from the beat then offered. Because the model knows whether each offered beat will be taken, beats offered during tail cycles or outside a frame are checked by the absence of any group in the following cycle.

// File: rtl/turbo_enc_pkg.sv
`timescale 1ns/1ps
package turbo_enc_pkg;

    localparam int CONSTR_LEN = 4;
    localparam int MEM_DEPTH  = CONSTR_LEN - 1;
    localparam int TAIL_LEN   = MEM_DEPTH;
    localparam int CNT_W      = $clog2(TAIL_LEN + 1);
    localparam int NUM_ENC    = 2;

    // delay line, index 1 is the newest bit
    typedef logic [MEM_DEPTH:1] rsc_state_t;
    // polynomial, bit i is the coefficient of D^i
    typedef logic [MEM_DEPTH:0] rsc_poly_t;

    typedef struct packed {
        logic sys;
        logic par0;
        logic par1;
    } rsc_out_t;

    typedef struct packed {
        logic x;
        logic y0;
        logic y1;
        logic y0i;
        logic y1i;
    } sym_group_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_TAIL
    } ctrl_state_t;

    function automatic logic tap_xor(input rsc_state_t st, input rsc_poly_t poly);
        logic acc;
        acc = 1'b0;
        for (int i = 1; i <= MEM_DEPTH; i++) begin
            acc = acc ^ (poly[i] & st[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/enc_ctrl.sv
`timescale 1ns/1ps
module enc_ctrl
    import turbo_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    output logic in_ready,
    output logic take,
    output logic start,
    output logic term,
    output logic term_last
);

    ctrl_state_t          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;

    always_comb begin
        in_ready  = (state_q != ST_TAIL);
        take      = in_valid && in_ready && (in_sof || state_q == ST_FRAME);
        start     = take && in_sof;
        term      = (state_q == ST_TAIL);
        term_last = term && (cnt_q == CNT_W'(TAIL_LEN - 1));
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_FRAME: begin
                if (take) begin
                    state_d = in_eof ? ST_TAIL : ST_FRAME;
                    cnt_d   = '0;
                end
            end
            ST_TAIL: begin
                cnt_d = cnt_q + 1'b1;
                if (term_last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // tail phase runs without a gap until its final step
    assert_tail_unbroken_R7: assert property (@(posedge clk) disable iff (rst)
        (term && !term_last) |=> term);

endmodule

// File: rtl/rsc_core.sv
`timescale 1ns/1ps
module rsc_core
    import turbo_enc_pkg::*;
#(
    parameter rsc_poly_t FB_POLY = 4'b1101,
    parameter rsc_poly_t P0_POLY = 4'b1011,
    parameter rsc_poly_t P1_POLY = 4'b1111
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  logic     start,
    input  logic     term,
    input  logic     term_last,
    input  logic     msg_bit,
    output rsc_out_t res
);

    rsc_state_t st_q, cur, nxt;
    logic       fb, u, node;

    always_comb begin
        cur  = start ? '0 : st_q;
        fb   = tap_xor(cur, FB_POLY);
        u    = term ? fb : msg_bit;
        node = u ^ fb;
        res.sys  = u;
        res.par0 = (P0_POLY[0] & node) ^ tap_xor(cur, P0_POLY);
        res.par1 = (P1_POLY[0] & node) ^ tap_xor(cur, P1_POLY);
        nxt[1] = node;
        for (int i = 2; i <= MEM_DEPTH; i++) begin
            nxt[i] = cur[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (step) begin
            st_q <= nxt;
        end
    end

    // termination returns the delay line to zero
    assert_zero_after_tail_R8: assert property (@(posedge clk) disable iff (rst)
        (step && term_last) |=> (st_q == '0));

endmodule

// File: rtl/turbo_encoder.sv
`timescale 1ns/1ps
module turbo_encoder
    import turbo_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_bit,
    input  logic       in_ibit,
    output logic       out_valid,
    output logic [4:0] out_sym,
    output logic       out_tail
);

    logic       take, start, term, term_last, step;
    logic       enc_in  [NUM_ENC];
    rsc_out_t   enc_res [NUM_ENC];
    sym_group_t grp_d, grp_q;
    logic       valid_q, tail_q;

    enc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .take      (take),
        .start     (start),
        .term      (term),
        .term_last (term_last)
    );

    assign step      = take || term;
    assign enc_in[0] = in_bit;
    assign enc_in[1] = in_ibit;

    for (genvar e = 0; e < NUM_ENC; e++) begin : g_enc
        rsc_core u_rsc (
            .clk       (clk),
            .rst       (rst),
            .step      (step),
            .start     (start),
            .term      (term),
            .term_last (term_last),
            .msg_bit   (enc_in[e]),
            .res       (enc_res[e])
        );
    end

    always_comb begin
        grp_d.x   = enc_res[0].sys;
        grp_d.y0  = enc_res[0].par0;
        grp_d.y1  = enc_res[0].par1;
        grp_d.y0i = enc_res[1].par0;
        grp_d.y1i = enc_res[1].par1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tail_q  <= 1'b0;
            grp_q   <= '0;
        end else begin
            valid_q <= step;
            tail_q  <= term;
            if (step) grp_q <= grp_d;
        end
    end

    assign out_valid = valid_q;
    assign out_tail  = tail_q;
    assign out_sym   = grp_q;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    assert_group_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_valid && !out_tail));

    assert_eof_then_tail_R7: assert property (@(posedge clk) disable iff (rst)
        (take && in_eof) |=> (out_valid && !out_tail) ##1 (out_valid && out_tail)
                             ##1 (out_valid && out_tail) ##1 (out_valid && out_tail));

    assert_no_data_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !(out_valid && !out_tail));

    // second encoder applies the interleaved bit on data beats (R5)
    assert_second_input_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !term) |-> (enc_res[1].sys == in_ibit));

endmodule

// File: tb/test_turbo_encoder.sv
`timescale 1ns/1ps
module test_turbo_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_bit = 1'b0, in_ibit = 1'b0;
    logic       in_ready, out_valid, out_tail;
    logic [4:0] out_sym;

    always #4 clk = ~clk;

    turbo_encoder i_turbo_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_eof(in_eof), .in_bit(in_bit), .in_ibit(in_ibit),
        .out_valid(out_valid), .out_sym(out_sym), .out_tail(out_tail)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state: s[0] newest delay bit
    bit [2:0] s1, s2;
    bit       m_frame;
    int       m_tail;
    bit       exp_valid, exp_tail;
    bit [4:0] exp_sym;

    function automatic void ref_step(inout bit [2:0] s, input bit term, input bit b,
                                     output bit sys, output bit p0, output bit p1);
        bit f, u, a;
        f   = s[1] ^ s[2];
        u   = term ? f : b;
        a   = u ^ f;
        p0  = a ^ s[0] ^ s[2];
        p1  = a ^ s[0] ^ s[1] ^ s[2];
        sys = u;
        s   = {s[1], s[0], a};
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) got %0h expected %0h at %0t", tag, cur_req, got, exp, $time);
        end
    endtask

    task automatic compare();
        chk(in_ready == (m_tail == 0), "R9 in_ready", in_ready, (m_tail == 0));
        chk(out_valid == exp_valid, "R2 out_valid", out_valid, exp_valid);
        if (exp_valid) begin
            chk(out_tail == exp_tail, "R7 out_tail", out_tail, exp_tail);
            chk(out_sym[4] == exp_sym[4], exp_tail ? "R8 tail X" : "R3 X", out_sym[4], exp_sym[4]);
            chk(out_sym[3:2] == exp_sym[3:2], "R4 Y0Y1", out_sym[3:2], exp_sym[3:2]);
            chk(out_sym[1:0] == exp_sym[1:0], "R5 Y0'Y1'", out_sym[1:0], exp_sym[1:0]);
        end
    endtask

    task automatic predict(input bit v, input bit sof, input bit eof, input bit b, input bit ib);
        bit x, p0, p1, xi, q0, q1;
        exp_valid = 0;
        exp_tail  = 0;
        if (m_tail > 0) begin
            ref_step(s1, 1'b1, 1'b0, x, p0, p1);
            ref_step(s2, 1'b1, 1'b0, xi, q0, q1);
            exp_sym   = {x, p0, p1, q0, q1};
            exp_valid = 1;
            exp_tail  = 1;
            m_tail--;
        end else if (v && (sof || m_frame)) begin
            if (sof) begin
                s1 = '0;
                s2 = '0;
            end
            ref_step(s1, 1'b0, b, x, p0, p1);
            ref_step(s2, 1'b0, ib, xi, q0, q1);
            exp_sym   = {x, p0, p1, q0, q1};
            exp_valid = 1;
            if (eof) begin
                m_tail  = 3;
                m_frame = 0;
            end else begin
                m_frame = 1;
            end
        end
    endtask

    task automatic cycle(input bit v, input bit sof, input bit eof, input bit b, input bit ib);
        @(negedge clk);
        compare();
        in_valid = v;
        in_sof   = sof;
        in_eof   = eof;
        in_bit   = b;
        in_ibit  = ib;
        predict(v, sof, eof, b, ib);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0);
    endtask

    // mode 0: random bits, 1: all ones; gaps inserts idle beats
    task automatic send_frame(input int n, input int mode, input bit gaps);
        for (int i = 0; i < n; i++) begin
            bit b, ib;
            b  = (mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
            ib = (mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
            if (gaps && $urandom_range(0, 3) == 0) cycle(0, 0, 0, 0, 0);
            cycle(1, i == 0, i == n - 1, b, ib);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        s1 = '0; s2 = '0; m_frame = 0; m_tail = 0;
        exp_valid = 0; exp_tail = 0; exp_sym = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs held by reset
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        cur_req = "R3";
        send_frame(16, 0, 0);
        idle(5);

        cur_req = "R9";
        send_frame(5, 0, 0);
        for (int i = 0; i < 4; i++) cycle(1, 1, 0, 1, 1); // refused in tail, last opens a frame
        cycle(1, 0, 1, 0, 1);
        idle(5);

        cur_req = "R10";
        for (int i = 0; i < 5; i++) cycle(1, 0, i == 4, 1, 1);
        idle(2);

        cur_req = "R11";
        cycle(1, 1, 1, 1, 0);
        idle(5);
        cycle(1, 1, 1, 0, 1);
        idle(5);

        cur_req = "R6";
        for (int i = 0; i < 6; i++) cycle(1, i == 0, 0, 1'($urandom_range(0, 1)), 1);
        cycle(1, 1, 0, 1, 0);
        for (int i = 0; i < 5; i++) cycle(1, 0, i == 4, 1'($urandom_range(0, 1)), 0);
        idle(5);

        cur_req = "R8";
        send_frame(12, 1, 0);
        idle(5);

        cur_req = "R2";
        send_frame(60, 0, 1);
        idle(6);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule